// File: doc/BRIEF.md
# Pin Edge Latch Interrupt Unit

This block watches a group of control input lines (six by default) for rising and falling transitions. Each line has two enable bits, one for each direction. The lines are first brought into the clock domain and then compared sample to sample. An enabled transition goes into a per-line capture flop that software cannot read. From there it moves into a visible "held" flag, and the move raises one shared pending flag. The transition is detected the same way whether the line is driven from outside or by this chip.

Each line has two bits in the status word. The first is the held flag. The second is a level bit that reads 1 when the line is low. While the held flag is clear, the level bit follows the line. Once the flag is set, the level bit keeps the value it had when the flag was set. Any later transitions stay in the hidden capture flop until software releases the line. Software reaches three words through a simple read/write port: the enable word, the status word and the pending word. The pending flag is also driven out on its own pin. Vectoring, and the gating of the request by any enables, are left to the logic that surrounds this block.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, the held flags are 0, the pending flag and `irq_pend` are 0, and the enable word reads 0.
- R2: For line i, an enabled transition sets held flag i (status bit i) and the pending flag. The change is seen after the fourth rising clock edge that follows the input change, and not after the third. Other lines are not affected.
- R3: A transition whose enable bit is 0 sets neither the held flag nor the pending flag.
- R4: While held flag i is 0, status bit NPIN+i reads the inverse of the synchronized line level: 1 means low.
- R5: While held flag i is 1, status bit NPIN+i keeps the value it had when the flag was set, whatever the line does.
- R6: An enabled transition that arrives while held flag i is 1 leaves the status unchanged. After software releases the line, the flag sets again and the pending flag is raised.
- R7: Writing a 1 to status bit i (address 1) clears held flag i. Writing a 0 there has no effect.
- R8: The pending command is write data bits [1:0] at address 2: 01 sets the flag, 10 clears it, and 00 or 11 leave it as it is. The flag reads back at bit 0 of address 2.
- R9: If a hardware set and a software clear of the pending flag fall in the same cycle, the flag ends up set.
- R10: Address 0 holds the enables: bit i enables rising transitions on line i, and bit NPIN+i enables falling transitions. The word reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | NPIN | Asynchronous control lines |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 enables, 1 status, 2 pending) |
| wr_data | input | 2*NPIN | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 2*NPIN | Read data, combinational |
| irq_pend | output | 1 | Pending flag |

## Verification
The bench uses the default of six lines. At that size every line can be tried with every pair of enable values and both starting levels, 48 cases in all. Each case also sends back the opposite transition while the line is held. This covers the hidden capture, the frozen level bit and the set that follows a release for every combination. Fixed cycle counting places a software clear on the same edge as a hardware set, which checks R9 together with the latency boundary in R2.

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
  parameter int NPIN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [2*NPIN-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [2*NPIN-1:0] rd_data,
  output logic              irq_pend
);
  localparam int W = 2 * NPIN;
  localparam logic [1:0] A_ARM  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_PEND = 2'd2;

  logic [NPIN-1:0] arm_rise, arm_fall;
  logic [NPIN-1:0] sy1, sy2, prev;
  logic [NPIN-1:0] det, held, frz;
  logic            pend;

  logic [NPIN-1:0] edge_ev, xfer, release_m, dbit;
  logic            wr_arm, wr_stat, wr_pend, pcmd_set, pcmd_clr;

  assign wr_arm  = wr_en && (wr_addr == A_ARM);
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign wr_pend = wr_en && (wr_addr == A_PEND);
  assign pcmd_set = wr_pend && (wr_data[1:0] == 2'b01);
  assign pcmd_clr = wr_pend && (wr_data[1:0] == 2'b10);

  assign edge_ev   = (sy2 & ~prev & arm_rise) | (~sy2 & prev & arm_fall);
  assign xfer      = det & ~held;
  assign release_m = wr_stat ? wr_data[NPIN-1:0] : '0;
  assign dbit      = (held & frz) | (~held & ~sy2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1  <= '0;
      sy2  <= '0;
      prev <= '0;
    end else begin
      sy1  <= pin_in;
      sy2  <= sy1;
      prev <= sy2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_rise <= '0;
      arm_fall <= '0;
    end else if (wr_arm) begin
      arm_rise <= wr_data[NPIN-1:0];
      arm_fall <= wr_data[W-1:NPIN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det  <= '0;
      held <= '0;
      frz  <= '0;
      pend <= 1'b0;
    end else begin
      det  <= (det & ~xfer) | edge_ev;
      held <= (held & ~release_m) | xfer;
      frz  <= (frz & ~xfer) | (~sy2 & xfer);
      pend <= (|xfer) | pcmd_set | (pend & ~pcmd_clr);
    end
  end

  always_comb begin
    case (rd_addr)
      A_ARM:   rd_data = {arm_fall, arm_rise};
      A_STAT:  rd_data = {dbit, held};
      A_PEND:  rd_data = {{(W-1){1'b0}}, pend};
      default: rd_data = '0;
    endcase
  end

  assign irq_pend = pend;

  p_pend_on_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(held & ~$past(held))) |-> pend);

  p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|xfer) |-> pend);

  p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pcmd_clr && !(|xfer)) |-> !pend);

  for (genvar i = 0; i < NPIN; i++) begin : g_chk
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wr_data[i] && held[i]) |=> !held[i]);

    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (held[i] && $past(held[i])) |-> $stable(dbit[i]));

    p_hidden_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (held[i] && !$past(held[i])) |-> $past(det[i]));
  end
endmodule

// File: tb/tb_pin_edge_irq.sv
module tb_pin_edge_irq;
  localparam int NPIN = 6;
  localparam int W = 2 * NPIN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPIN-1:0] pin_in = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [W-1:0] rd_data;
  logic irq_pend;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pin_edge_irq #(.NPIN(NPIN)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_pend(irq_pend)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    rd(2'd1, v); chk(v[NPIN-1:0] == '0, "R1 held flags", v, '0);
    rd(2'd2, v); chk(v == '0 && irq_pend == 1'b0, "R1 pending", v, '0);
    rd(2'd0, v); chk(v == '0, "R1 enables", v, '0);

    wr(2'd0, 12'hA5C); rd(2'd0, v); chk(v == 12'hA5C, "R10 enable readback", v, 12'hA5C);
    wr(2'd0, 12'h3F0); rd(2'd0, v); chk(v == 12'h3F0, "R10 enable readback", v, 12'h3F0);
    wr(2'd0, '0);

    wr(2'd2, 12'h001); rd(2'd2, v); chk(v == 12'h001 && irq_pend, "R8 set cmd", v, 12'h001);
    wr(2'd2, 12'h000); rd(2'd2, v); chk(v == 12'h001, "R8 cmd 00 no change", v, 12'h001);
    wr(2'd2, 12'h003); rd(2'd2, v); chk(v == 12'h001, "R8 cmd 11 no change", v, 12'h001);
    wr(2'd2, 12'h002); rd(2'd2, v); chk(v == 12'h000 && !irq_pend, "R8 clear cmd", v, 12'h000);
    wr(2'd2, 12'h003); rd(2'd2, v); chk(v == 12'h000, "R8 cmd 11 keeps clear", v, 12'h000);

    // R9 and R2 latency: line 0 rising, software clear lands on the fourth edge
    wr(2'd0, 12'h001);
    @(negedge clk); pin_in[0] = 1'b1;
    cyc(3);
    rd(2'd1, v); chk(v[0] == 1'b0, "R2 not held after third edge", v[0], 0);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 12'h002;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    rd(2'd1, v); chk(v[0] == 1'b1, "R2 held after fourth edge", v[0], 1);
    chk(irq_pend == 1'b1, "R9 hardware set beats clear", irq_pend, 1);
    wr(2'd0, '0);
    @(negedge clk); pin_in = '0;
    cyc(5);
    wr(2'd1, 12'h03F); wr(2'd2, 12'h002);

    for (int p = 0; p < NPIN; p++)
      for (int ra = 0; ra < 2; ra++)
        for (int fa = 0; fa < 2; fa++)
          for (int dir = 0; dir < 2; dir++) begin
            logic start, armed, oa;
            logic [NPIN-1:0] hm;
            start = (dir == 1) ? 1'b0 : 1'b1;
            armed = (dir == 1) ? ra[0] : fa[0];
            oa    = (dir == 1) ? fa[0] : ra[0];
            hm    = '0;
            wr(2'd0, '0);
            @(negedge clk); pin_in = '0; pin_in[p] = start;
            cyc(5);
            wr(2'd1, 12'h03F); wr(2'd2, 12'h002);
            rd(2'd1, v);
            chk(v[NPIN-1:0] == '0, "R7 all released", v, '0);
            chk(v[NPIN+p] == ~start, "R4 transparent level", v[NPIN+p], ~start);
            wr(2'd0, (W'(ra) << p) | (W'(fa) << (p + NPIN)));

            @(negedge clk); pin_in[p] = ~start;
            cyc(5);
            hm[p] = armed;
            rd(2'd1, v);
            chk(v[NPIN-1:0] == hm, armed ? "R2 enabled edge held" : "R3 disabled edge ignored", v[NPIN-1:0], hm);
            chk(irq_pend == armed, armed ? "R2 pending raised" : "R3 no pending", irq_pend, armed);
            chk(v[NPIN+p] == start, "R4 level after edge", v[NPIN+p], start);

            @(negedge clk); pin_in[p] = start;
            cyc(5);
            hm[p] = armed | oa;
            rd(2'd1, v);
            chk(v[NPIN-1:0] == hm, armed ? "R6 later edge kept hidden" : "R3 return edge", v[NPIN-1:0], hm);
            chk(v[NPIN+p] == (armed ? start : ~start), armed ? "R5 level frozen" : "R4 level follows", v[NPIN+p], armed ? start : ~start);

            wr(2'd1, '0);
            rd(2'd1, v);
            chk(v[NPIN-1:0] == hm, "R7 write 0 no effect", v[NPIN-1:0], hm);

            wr(2'd2, 12'h002);
            wr(2'd1, W'(1) << p);
            cyc(2);
            hm[p] = armed & oa;
            rd(2'd1, v);
            chk(v[NPIN-1:0] == hm, "R6 set again after release", v[NPIN-1:0], hm);
            chk(irq_pend == (armed & oa), "R6 pending after release", irq_pend, armed & oa);
            chk(v[NPIN+p] == ~start, "R5 level after release", v[NPIN+p], ~start);
          end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule